// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller with Acknowledge

This block pairs two eight-line priority interrupt controllers to serve sixteen level request inputs. Lines 0 to 7 feed the primary controller and lines 8 to 15 feed the secondary one. When the secondary controller selects a request, it raises primary line 2. A single interrupt output goes to the processor.

The processor answers an interrupt with a one-cycle acknowledge strobe. One cycle later the block returns an 8-bit vector together with a done flag. In the same step it moves the served line from pending to in-service in every controller involved, then re-evaluates priorities.

A small command port covers the parts of programming that the block needs in order to run. It can load either controller's mask, and it can issue a non-specific end-of-interrupt, which retires the highest-priority in-service line. Vector bases are fixed parameters: 0x08 for the primary and 0x70 for the secondary.

Top module: `cascade_irq_ack`

## Requirements
- R1: After reset, intr_out and ack_done are 0 and every line of both controllers is masked (mask = 0xFF), so a rising request produces no interrupt.
- R2: A 0-to-1 edge on irq_in[n], for n in 0..7 with n unmasked and not blocked, raises intr_out one clock later. The acknowledged vector is 0x08 + n.
- R3: A 0-to-1 edge on irq_in[n], for n in 8..15, is served by the secondary controller. That controller raises primary line 2, intr_out rises one clock later, and the acknowledged vector is 0x70 + (n - 8).
- R4: A request is latched only on a 0-to-1 transition. A line held high after it has been served raises no new interrupt.
- R5: When an input falls, its latched request is cleared only if that line is masked at that moment. A request that falls while unmasked stays pending.
- R6: A lower line number has higher priority. A pending line is not granted while an in-service line of equal or higher priority exists in the same controller.
- R7: An ack pulse while intr_out is 1 drops intr_out (unless another request is eligible), sets the in-service bit of the served line, and gives ack_done = 1 with vec_out valid in the next cycle. An ack while intr_out is 0 is ignored (ack_done stays 0).
- R8: Acknowledging primary line 2 updates both controllers. Primary in-service bit 2 is set, so primary lines 3..7 stay blocked until a primary EOI, while lines 0..1 still interrupt.
- R9: Command cmd_eoi = 0 loads cmd_data as the mask of the controller chosen by cmd_slave (1 = secondary; mask bit 1 = line masked). cmd_eoi = 1 clears the lowest-numbered set in-service bit of that controller and re-evaluates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Level request lines |
| ack | input | 1 | One-cycle processor acknowledge strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_slave | input | 1 | Command target: 0 primary, 1 secondary |
| cmd_eoi | input | 1 | 1 = non-specific EOI, 0 = mask load |
| cmd_data | input | 8 | Mask value for a mask load |
| intr_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| ack_done | output | 1 | One-cycle flag: vec_out is valid |

## Verification
The hardest state to reach is a nested cascade. A secondary line is in service, which leaves primary line 2 in service, and two more primary requests are pending: one above the cascade line in priority and one below it. The bench reaches this by acknowledging a secondary line and raising primary lines 4 and 1. It then checks that line 1 interrupts at once, while line 4 waits for the end-of-interrupt sequence on both controllers. The rule that a falling input clears only a masked request is reached in a similar way. Line 0 is held in service so that an unmasked line 5 can fall while it is still pending.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
  localparam int          LINES_DEF   = 8;
  localparam int          CASCADE_DEF = 2;
  localparam int          VECW_DEF    = 8;
  localparam logic [7:0]  PRI_BASE    = 8'h08;
  localparam logic [7:0]  SEC_BASE    = 8'h70;

  typedef enum logic {
    CMD_MASK = 1'b0,
    CMD_EOI  = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] insvc,
  output logic             hit,
  output logic [IDXW-1:0]  idx
);
  logic [LINES-1:0] elig;
  logic             stop;

  assign elig = req & ~mask;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    stop = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!stop) begin
        if (insvc[i]) begin
          stop = 1'b1;
        end else if (elig[i]) begin
          hit  = 1'b1;
          idx  = IDXW'(i);
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  logic [LINES-1:0] casc_set,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_data,
  input  logic             eoi,
  input  logic             ack_take,
  output logic             pend,
  output logic [IDXW-1:0]  lat,
  output logic             grant,
  output logic [LINES-1:0] isr_q
);
  logic [LINES-1:0] irr_q, imr_q;
  logic [LINES-1:0] irr1, imr1, isr1, lat_bit;
  logic             pend1, hit;
  logic [IDXW-1:0]  idx;

  assign lat_bit = LINES'(1) << lat;

  always_comb begin
    irr1  = (irr_q | rise | casc_set) & ~(fall & imr_q);
    imr1  = mask_we ? mask_data : imr_q;
    isr1  = eoi ? (isr_q & ~(isr_q & (~isr_q + 1'b1))) : isr_q;
    pend1 = pend;
    if (ack_take) begin
      isr1  = isr1 | lat_bit;
      irr1  = irr1 & ~lat_bit;
      pend1 = 1'b0;
    end
  end

  irq_resolver #(.LINES(LINES)) u_res (
    .req(irr1), .mask(imr1), .insvc(isr1), .hit(hit), .idx(idx)
  );

  assign grant = hit & ~pend1;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      imr_q <= '1;
      isr_q <= '0;
      pend  <= 1'b0;
      lat   <= '0;
    end else begin
      imr_q <= imr1;
      isr_q <= isr1;
      pend  <= pend1 | grant;
      if (grant) begin
        lat   <= idx;
        irr_q <= irr1 & ~(LINES'(1) << idx);
      end else begin
        irr_q <= irr1;
      end
    end
  end
endmodule

// File: rtl/cascade_irq_ack.sv
module cascade_irq_ack
  import cascade_irq_pkg::*;
#(
  parameter int         LINES    = LINES_DEF,
  parameter int         CASCADE  = CASCADE_DEF,
  parameter int         VECW     = VECW_DEF,
  parameter logic [7:0] BASE_PRI = PRI_BASE,
  parameter logic [7:0] BASE_SEC = SEC_BASE,
  localparam int        IDXW     = $clog2(LINES),
  localparam int        TOTAL    = 2 * LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] irq_in,
  input  logic             ack,
  input  logic             cmd_valid,
  input  logic             cmd_slave,
  input  logic             cmd_eoi,
  input  logic [LINES-1:0] cmd_data,
  output logic             intr_out,
  output logic [VECW-1:0]  vec_out,
  output logic             ack_done
);
  logic [TOTAL-1:0] irq_q, rise, fall;
  logic             m_pend, s_pend, m_grant, s_grant;
  logic [IDXW-1:0]  m_lat, s_lat;
  logic [LINES-1:0] m_isr, s_isr, casc_vec;
  logic             m_take, s_take, is_mask, is_eoi;

  assign rise     = irq_in & ~irq_q;
  assign fall     = ~irq_in & irq_q;
  assign m_take   = ack & m_pend;
  assign s_take   = m_take & (m_lat == IDXW'(CASCADE));
  assign is_mask  = cmd_valid & (cmd_eoi == CMD_MASK);
  assign is_eoi   = cmd_valid & (cmd_eoi == CMD_EOI);
  assign casc_vec = s_grant ? (LINES'(1) << CASCADE) : '0;

  irq_unit #(.LINES(LINES)) u_sec (
    .clk(clk), .rst(rst),
    .rise(rise[TOTAL-1:LINES]), .fall(fall[TOTAL-1:LINES]),
    .casc_set('0),
    .mask_we(is_mask & cmd_slave), .mask_data(cmd_data),
    .eoi(is_eoi & cmd_slave), .ack_take(s_take),
    .pend(s_pend), .lat(s_lat), .grant(s_grant), .isr_q(s_isr)
  );

  irq_unit #(.LINES(LINES)) u_pri (
    .clk(clk), .rst(rst),
    .rise(rise[LINES-1:0]), .fall(fall[LINES-1:0]),
    .casc_set(casc_vec),
    .mask_we(is_mask & ~cmd_slave), .mask_data(cmd_data),
    .eoi(is_eoi & ~cmd_slave), .ack_take(m_take),
    .pend(m_pend), .lat(m_lat), .grant(m_grant), .isr_q(m_isr)
  );

  assign intr_out = m_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= '0;
      vec_out  <= '0;
      ack_done <= 1'b0;
    end else begin
      irq_q    <= irq_in;
      ack_done <= m_take;
      if (m_take) begin
        if (s_take) vec_out <= VECW'(BASE_SEC) + VECW'(s_lat);
        else        vec_out <= VECW'(BASE_PRI) + VECW'(m_lat);
      end
    end
  end
endmodule

module cascade_irq_ack_chk #(
  parameter int         LINES    = 8,
  parameter int         CASCADE  = 2,
  parameter int         VECW     = 8,
  parameter logic [7:0] BASE_PRI = 8'h08,
  parameter logic [7:0] BASE_SEC = 8'h70
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             intr_out,
  input logic             ack_done,
  input logic [VECW-1:0]  vec_out,
  input logic             m_grant,
  input logic [LINES-1:0] m_isr,
  input logic [LINES-1:0] s_isr
);
  localparam logic [VECW-1:0] LOWM = VECW'(LINES - 1);
  logic sec_vec;
  assign sec_vec = (vec_out & ~LOWM) == VECW'(BASE_SEC);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!intr_out && !ack_done));
  // R7
  done_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_done |-> $past(ack && intr_out));
  // R7
  ack_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && intr_out) |=> ack_done);
  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    ack_done |-> ((vec_out & ~LOWM) == VECW'(BASE_PRI) || sec_vec));
  // R8
  cascade_insvc_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_done && sec_vec) |-> (m_isr[CASCADE] && s_isr[vec_out[$clog2(LINES)-1:0]]));
  // R6
  grant_raises_chk: assert property (@(posedge clk) disable iff (rst)
    m_grant |=> intr_out);
endmodule

bind cascade_irq_ack cascade_irq_ack_chk #(
  .LINES(LINES), .CASCADE(CASCADE), .VECW(VECW),
  .BASE_PRI(BASE_PRI), .BASE_SEC(BASE_SEC)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .intr_out(intr_out),
  .ack_done(ack_done), .vec_out(vec_out), .m_grant(m_grant),
  .m_isr(m_isr), .s_isr(s_isr)
);

// File: tb/test_cascade_irq_ack.sv
module test_cascade_irq_ack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq = '0;
  logic        ack = 1'b0;
  logic        cmd_valid = 1'b0, cmd_slave = 1'b0, cmd_eoi = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        intr_out, ack_done;
  logic [7:0]  vec_out;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cascade_irq_ack i_cascade_irq_ack (
    .clk(clk), .rst(rst), .irq_in(irq), .ack(ack),
    .cmd_valid(cmd_valid), .cmd_slave(cmd_slave), .cmd_eoi(cmd_eoi),
    .cmd_data(cmd_data), .intr_out(intr_out), .vec_out(vec_out),
    .ack_done(ack_done)
  );

  // {line, expected vector}
  localparam logic [11:0] TBL [6] = '{
    {4'd0, 8'h08}, {4'd3, 8'h0B}, {4'd7, 8'h0F},
    {4'd8, 8'h70}, {4'd11, 8'h73}, {4'd15, 8'h77}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic ack_once();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic cmd(input logic sl, input logic eo, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_slave = sl; cmd_eoi = eo; cmd_data = d;
    cyc();
    cmd_valid = 1'b0;
  endtask

  task automatic ack_expect(input string req, input logic [7:0] v);
    ack_once();
    chk(req, {7'd0, ack_done}, 8'd1);
    chk(req, vec_out, v);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 intr", {7'd0, intr_out}, 8'd0);
    chk("R1 ack_done", {7'd0, ack_done}, 8'd0);
    irq[5] = 1'b1; cyc(); cyc();
    chk("R1 masked line", {7'd0, intr_out}, 8'd0);
    irq[5] = 1'b0; cyc();             // R5 masked fall clears
    cmd(1'b0, 1'b0, 8'h00);
    cmd(1'b1, 1'b0, 8'h00);
    cyc();
    chk("R5 masked fall cleared", {7'd0, intr_out}, 8'd0);

    // table walk: R2 R3 R7
    for (int k = 0; k < 6; k++) begin
      int ln;
      ln = int'(TBL[k][11:8]);
      irq[ln] = 1'b1; cyc();
      chk(ln < 8 ? "R2 intr" : "R3 intr", {7'd0, intr_out}, 8'd1);
      ack_expect(ln < 8 ? "R2 vector" : "R3 vector", TBL[k][7:0]);
      chk("R7 intr drop", {7'd0, intr_out}, 8'd0);
      cyc();
      chk("R7 done pulse", {7'd0, ack_done}, 8'd0);
      irq[ln] = 1'b0;
      if (ln >= 8) cmd(1'b1, 1'b1, 8'h00);
      cmd(1'b0, 1'b1, 8'h00);
    end

    // R6 priority and blocking
    irq[6] = 1'b1; irq[4] = 1'b1; cyc();
    ack_expect("R6 lower wins", 8'h0C);
    chk("R6 blocked by insvc", {7'd0, intr_out}, 8'd0);
    irq[1] = 1'b1; cyc();
    chk("R6 higher preempts", {7'd0, intr_out}, 8'd1);
    ack_expect("R6 vector 1", 8'h09);
    cmd(1'b0, 1'b1, 8'h00);
    chk("R9 eoi leaves line4", {7'd0, intr_out}, 8'd0);
    cmd(1'b0, 1'b1, 8'h00);
    chk("R9 eoi releases", {7'd0, intr_out}, 8'd1);
    ack_expect("R6 vector 6", 8'h0E);
    cmd(1'b0, 1'b1, 8'h00);
    irq[1] = 1'b0; irq[4] = 1'b0; irq[6] = 1'b0; cyc();

    // R4 held level does not re-request
    irq[3] = 1'b1; cyc();
    ack_expect("R4 vector", 8'h0B);
    cmd(1'b0, 1'b1, 8'h00);
    cyc();
    chk("R4 held high", {7'd0, intr_out}, 8'd0);
    irq[3] = 1'b0; cyc();

    // R5 unmasked fall keeps request
    irq[0] = 1'b1; cyc();
    ack_expect("R5 setup", 8'h08);
    irq[5] = 1'b1; cyc();
    irq[5] = 1'b0; cyc();
    chk("R5 still blocked", {7'd0, intr_out}, 8'd0);
    cmd(1'b0, 1'b1, 8'h00);
    chk("R5 kept pending", {7'd0, intr_out}, 8'd1);
    ack_expect("R5 vector", 8'h0D);
    cmd(1'b0, 1'b1, 8'h00);
    irq[0] = 1'b0; cyc();

    // R8 nested cascade
    irq[12] = 1'b1; cyc();
    ack_expect("R8 slave vector", 8'h74);
    irq[4] = 1'b1; cyc();
    chk("R8 line4 blocked", {7'd0, intr_out}, 8'd0);
    irq[1] = 1'b1; cyc();
    chk("R8 line1 passes", {7'd0, intr_out}, 8'd1);
    ack_expect("R8 vector 1", 8'h09);
    cmd(1'b0, 1'b1, 8'h00);
    chk("R8 cascade still blocks", {7'd0, intr_out}, 8'd0);
    cmd(1'b1, 1'b1, 8'h00);
    cmd(1'b0, 1'b1, 8'h00);
    chk("R8 released", {7'd0, intr_out}, 8'd1);
    ack_expect("R8 vector 4", 8'h0C);
    cmd(1'b0, 1'b1, 8'h00);
    irq[1] = 1'b0; irq[4] = 1'b0; irq[12] = 1'b0; cyc();

    // R7 ack with nothing pending
    ack_once();
    chk("R7 idle ack", {7'd0, ack_done}, 8'd0);

    // R9 per-controller mask
    cmd(1'b1, 1'b0, 8'h02);
    irq[9] = 1'b1; cyc();
    chk("R9 slave mask", {7'd0, intr_out}, 8'd0);
    irq[10] = 1'b1; cyc();
    ack_expect("R9 vector 10", 8'h72);
    irq[9] = 1'b0; irq[10] = 1'b0; cyc();
    cmd(1'b1, 1'b1, 8'h00);
    cmd(1'b0, 1'b1, 8'h00);
    cmd(1'b1, 1'b0, 8'h00);
    cyc();
    chk("R5 slave masked fall cleared", {7'd0, intr_out}, 8'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule